// File: doc/BRIEF.md
# Multi-Channel Input Capture Timer

This block keeps a free-running 16-bit time base and timestamps external events on eight capture pins. The time base advances on a prescaled tick, a power-of-two fraction of the bus clock. Each pin passes through a two-stage synchroniser and a stability filter, so short glitches are discarded. A selectable edge detector then qualifies the change. On a qualified edge, the channel stores the current count in its own capture register and raises its flag. Flags whose per-channel enable is set drive a single interrupt line.

Software controls the block through a small register bus. The bus accepts a read or a write in every cycle and has no back-pressure. Writes take effect at the next clock edge, and read data is returned combinationally in the same cycle. No streaming data path crosses the block's edge, so every port is a plain control or status signal.

Top module: `capture_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The register map by address is:
  - 0: control. Bit 0 is the run enable and bits 3:1 are the prescale select.
  - 1: edge selection, two bits per channel, with channel i at bits 2i+1:2i.
  - 2: mode. Bits 7:0 are the capture-disable bits and bits 15:8 are the interrupt enables.
  - 3: status. Bits 7:0 are the channel flags and bit 8 is the overflow flag.
  - 4: the count, read-only.
  - 8 to 15: the capture registers of channels 0 to 7.
- R2: Suppose a pin changes level between clock edge k-1 and edge k and holds long enough to be recognised. The edge is then recognised at edge k+4, and the capture register stores the count value present just before that edge.
- R3: A capture sets the channel's flag, which is status bit i.
- R4: A pin level held for two or fewer clock samples is rejected and produces no edge. A level held for three or more samples is accepted.
- R5: The edge field selects the active edge. 00 captures nothing, 01 captures rising edges, 10 captures falling edges and 11 captures both.
- R6: A channel whose capture-disable bit is 1 neither captures nor sets its flag.
- R7: Writing 1 to a status bit clears that flag only while the run bit is 1. Writing 0 leaves the flag unchanged, and writing 1 while the timer is stopped leaves it unchanged.
- R8: `irq` is high exactly when some channel flag is set together with its interrupt enable. The overflow flag does not drive `irq`.
- R9: The prescale select s divides the bus clock by 2^s. Starting from a stopped timer, E clock edges after run is set the count has advanced by floor(E / 2^s).
- R10: The count wraps from 0xFFFF to 0, and that wrap sets status bit 8. Bit 8 is cleared under the same write-one rule as R7.
- R11: While the run bit is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_en` |
| cap_in | input | 8 | Capture pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the following about the inputs:
- The bus fields are defined whenever `bus_en` is high.
- A single status write is the only way a flag can fall.
- Capture pins are driven from the clock domain or already settled, so the synchroniser never carries an unknown value into the filter.

The stimulus respects these assumptions. It changes pins and bus fields only at the falling clock edge and issues one bus access per cycle. It derives every expected timestamp from a bench cycle count, taken relative to the edge at which run was set.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned REG_ADDR_W = 4;
  localparam int unsigned PRE_SEL_W  = 3;

  localparam logic [REG_ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [REG_ADDR_W-1:0] A_EDGE  = 4'd1;
  localparam logic [REG_ADDR_W-1:0] A_MODE  = 4'd2;
  localparam logic [REG_ADDR_W-1:0] A_STAT  = 4'd3;
  localparam logic [REG_ADDR_W-1:0] A_COUNT = 4'd4;
  localparam logic [REG_ADDR_W-1:0] A_CAP0  = 4'd8;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic [PRE_SEL_W-1:0] div_sel;
    logic                 run;
  } ctrl_t;
endpackage

// File: rtl/ct_timebase.sv
`timescale 1ns/1ps
module ct_timebase #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRE_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [PRE_SEL_W-1:0] div_sel,
  input  logic                 ovf_clr,
  output logic [CNT_W-1:0]     count,
  output logic                 ovf
);
  // prescaler width covers the largest divide (2^(2^PRE_SEL_W - 1))
  localparam int unsigned PRE_CNT_W = (1 << PRE_SEL_W) - 1;

  logic [PRE_CNT_W-1:0] pre_q;
  logic [PRE_CNT_W-1:0] pre_mask;
  logic                 tick;
  logic                 at_top;

  always_comb begin
    pre_mask = ~({PRE_CNT_W{1'b1}} << div_sel);
    tick     = run && ((pre_q & pre_mask) == pre_mask);
    at_top   = (count == {CNT_W{1'b1}});
  end

  // phase restarts whenever the timer is stopped
  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ovf <= 1'b0;
    else if (tick && at_top) ovf <= 1'b1;
    else if (ovf_clr)        ovf <= 1'b0;
  end
endmodule

// File: rtl/ct_pin_filter.sv
`timescale 1ns/1ps
module ct_pin_filter
  import ct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_STABLE  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       evt
);
  localparam int unsigned STAB_W = (MIN_STABLE > 1) ? $clog2(MIN_STABLE) : 1;
  localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(MIN_STABLE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic                   level_q;
  logic [STAB_W-1:0]      stab_q;
  logic                   flip;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign sync_out = sync_q[SYNC_STAGES-1];
  assign flip     = (sync_out != level_q) && (stab_q == STAB_LAST);

  // accepted level moves only after MIN_STABLE consecutive differing samples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      stab_q  <= '0;
    end else if (sync_out == level_q) begin
      stab_q  <= '0;
    end else if (flip) begin
      level_q <= sync_out;
      stab_q  <= '0;
    end else begin
      stab_q  <= stab_q + 1'b1;
    end
  end

  assign rise = flip &&  sync_out;
  assign fall = flip && !sync_out;

  always_comb begin
    case (mode)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/ct_channel.sv
`timescale 1ns/1ps
module ct_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             capture_off,
  input  logic [CNT_W-1:0] count,
  input  logic             clr,
  output logic             hit,
  output logic             flag,
  output logic [CNT_W-1:0] value
);
  assign hit = evt && !capture_off;

  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (hit) value <= count;
  end

  // a new capture wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/capture_timer.sv
`timescale 1ns/1ps
module capture_timer
  import ct_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_STABLE  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0]     cap_in,
  output logic                  irq
);
  localparam int unsigned EDGE_W = 2 * NUM_CH;

  ctrl_t                         ctrl_q;
  logic [EDGE_W-1:0]             edge_q;
  logic [NUM_CH-1:0]             ios_q;
  logic [NUM_CH-1:0]             ie_q;
  logic [CNT_W-1:0]              count;
  logic                          ovf;
  logic [NUM_CH-1:0]             evt;
  logic [NUM_CH-1:0]             cap_hit;
  logic [NUM_CH-1:0]             flags;
  logic [NUM_CH-1:0][CNT_W-1:0]  cap_vals;
  logic                          wr;
  logic                          stat_clr;
  logic [NUM_CH-1:0]             ch_clr;
  logic                          ovf_clr;

  assign wr       = bus_en && bus_we;
  assign stat_clr = wr && (bus_addr == A_STAT) && ctrl_q.run;
  assign ch_clr   = {NUM_CH{stat_clr}} & bus_wdata[NUM_CH-1:0];
  assign ovf_clr  = stat_clr && bus_wdata[NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      edge_q <= '0;
      ios_q  <= '0;
      ie_q   <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_CTRL: ctrl_q <= ctrl_t'(bus_wdata[PRE_SEL_W:0]);
        A_EDGE: edge_q <= bus_wdata[EDGE_W-1:0];
        A_MODE: begin
          ios_q <= bus_wdata[NUM_CH-1:0];
          ie_q  <= bus_wdata[2*NUM_CH-1:NUM_CH];
        end
        default: ;
      endcase
    end
  end

  ct_timebase #(.CNT_W(CNT_W), .PRE_SEL_W(PRE_SEL_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .div_sel (ctrl_q.div_sel),
    .ovf_clr (ovf_clr),
    .count   (count),
    .ovf     (ovf)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ct_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_STABLE(MIN_STABLE)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cap_in[i]),
      .mode  (edge_mode_e'(edge_q[2*i+1 -: 2])),
      .evt   (evt[i])
    );

    ct_channel #(.CNT_W(CNT_W)) u_channel (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt[i]),
      .capture_off (ios_q[i]),
      .count       (count),
      .clr         (ch_clr[i]),
      .hit         (cap_hit[i]),
      .flag        (flags[i]),
      .value       (cap_vals[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
        A_EDGE:  bus_rdata = DATA_W'(edge_q);
        A_MODE:  bus_rdata = DATA_W'({ie_q, ios_q});
        A_STAT:  bus_rdata = DATA_W'({ovf, flags});
        A_COUNT: bus_rdata = DATA_W'(count);
        default: begin
          for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == REG_ADDR_W'(A_CAP0 + i)) bus_rdata = DATA_W'(cap_vals[i]);
          end
        end
      endcase
    end
  end

  assign irq = |(flags & ie_q);
endmodule

// File: rtl/ct_checker.sv
`timescale 1ns/1ps
module ct_checker
  import ct_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_en,
  input logic                         bus_we,
  input logic [REG_ADDR_W-1:0]        bus_addr,
  input logic                         run,
  input logic [CNT_W-1:0]             count,
  input logic                         ovf,
  input logic [NUM_CH-1:0]            flags,
  input logic [NUM_CH-1:0]            cap_hit,
  input logic [NUM_CH-1:0][CNT_W-1:0] cap_vals,
  input logic                         irq
);
  logic stat_wr;
  assign stat_wr = bus_en && bus_we && (bus_addr == A_STAT);

  // R7: a flag may only fall after a status write made while running
  a_r7_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) != '0) |-> ($past(stat_wr) && $past(run)));

  // R8: an interrupt needs at least one raised channel flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  // R9: the count moves by at most one step per clock
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

  // R11: a stopped timer holds its count
  a_r11_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(count));

  // R10: overflow rises exactly as the count wraps to zero
  a_r10_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (count == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2: capture register takes the count of the edge cycle
    a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[i] |=> (cap_vals[i] == $past(count)));
    // R3: capture raises the channel flag
    a_r3_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[i] |=> flags[i]);
  end
endmodule

bind capture_timer ct_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .run      (ctrl_q.run),
  .count    (count),
  .ovf      (ovf),
  .flags    (flags),
  .cap_hit  (cap_hit),
  .cap_vals (cap_vals),
  .irq      (irq)
);

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  cap_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int c0 = 0;
  int base = 0;
  int divv = 1;
  logic [15:0] exp_cap [8];

  capture_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) exp_cap[i] = '0;
  endtask

  function automatic logic [15:0] cnt_at(input int c);
    return 16'((base + (c - c0) / divv) & 32'hFFFF);
  endfunction

  // stop, check hold (R11), restart with a fresh prescale phase
  task automatic start_run(input int sel);
    logic [15:0] a, b;
    wr(4'd0, 16'h0000);
    rd(4'd4, a);
    repeat (5) @(negedge clk);
    rd(4'd4, b);
    chk("R11 count held while stopped", b, a);
    base = a;
    divv = 1 << sel;
    wr(4'd0, 16'(1 | (sel << 1)));
    c0 = cyc;
  endtask

  task automatic trial(input int ch, input logic [1:0] mode, input bit ios_b,
                       input bit ie_b, input int len, input string req);
    logic [15:0] d;
    int c;
    bit fl;
    wr(4'd1, 16'(mode) << (2 * ch));
    wr(4'd2, 16'((ios_b << ch) | (ie_b << (8 + ch))));
    wr(4'd3, 16'h00FF);
    c = cyc;
    cap_in[ch] = 1'b1;
    repeat (len) @(negedge clk);
    cap_in[ch] = 1'b0;
    repeat (8) @(negedge clk);
    fl = 1'b0;
    if (!ios_b && len >= 3) begin
      if (mode[0]) begin exp_cap[ch] = cnt_at(c + 4); fl = 1'b1; end
      if (mode[1]) begin exp_cap[ch] = cnt_at(c + len + 4); fl = 1'b1; end
    end
    rd(4'd3, d);
    chk({req, " R3 flag"}, d[8:0], 9'(fl) << ch);
    rd(4'(8 + ch), d);
    chk({req, " R2 capture value"}, d, exp_cap[ch]);
    chk({req, " R8 irq"}, irq, fl && ie_b);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1c0ffee));
    do_reset();

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(4'(a), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 reset irq", irq, 0);

    // directed corner cases at divide-by-1
    start_run(0);
    trial(0, 2'b01, 0, 1, 3, "R4 three-sample pulse accepted");
    trial(1, 2'b01, 0, 1, 2, "R4 two-sample pulse rejected");
    trial(2, 2'b10, 0, 0, 5, "R5 falling only");
    trial(3, 2'b11, 0, 1, 6, "R5 both edges");
    trial(4, 2'b00, 0, 1, 6, "R5 edge disabled");
    trial(5, 2'b11, 1, 1, 6, "R6 capture disabled");

    // R7 clear rules
    trial(6, 2'b01, 0, 0, 4, "R7 setup");
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'h00FF);
    rd(4'd3, d);
    chk("R7 no clear while stopped", d[6], 1);
    start_run(0);
    wr(4'd3, 16'h0000);
    rd(4'd3, d);
    chk("R7 write zero keeps flag", d[6], 1);
    wr(4'd3, 16'h0040);
    rd(4'd3, d);
    chk("R7 write one clears flag", d[6], 0);

    // random trials across prescale settings
    for (int ph = 0; ph < 4; ph++) begin
      start_run((ph * 3) % 8);
      for (int t = 0; t < 10; t++) begin
        trial($urandom_range(7, 0), 2'($urandom_range(3, 0)),
              ($urandom_range(3, 0) == 0), $urandom_range(1, 0),
              $urandom_range(9, 1), "random");
      end
    end

    // R9 prescale rate from a fresh start
    for (int k = 0; k < 6; k++) begin
      int sel, e;
      sel = (k == 0) ? 7 : $urandom_range(7, 0);
      e = $urandom_range(700, 10);
      do_reset();
      wr(4'd0, 16'(1 | (sel << 1)));
      c0 = cyc;
      repeat (e) @(negedge clk);
      rd(4'd4, d);
      chk("R9 prescaled count", d, (cyc - c0) >> sel);
    end

    // R10 wrap and overflow flag
    do_reset();
    wr(4'd0, 16'h0001);
    c0 = cyc;
    repeat (65535) @(negedge clk);
    rd(4'd4, d);
    chk("R10 count at top", d, 16'hFFFF);
    rd(4'd3, d);
    chk("R10 no overflow yet", d, 0);
    @(negedge clk);
    rd(4'd4, d);
    chk("R10 count wrapped", d, 0);
    rd(4'd3, d);
    chk("R10 overflow flag", d, 16'h0100);
    chk("R8 overflow does not drive irq", irq, 0);
    wr(4'd3, 16'h0100);
    rd(4'd3, d);
    chk("R10 overflow cleared", d, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule